// File: doc/BRIEF.md
# Bus Wake-Up Edge Detector

This block watches a single-wire serial bus and a local wake pin while the node is asleep. It raises a one-cycle wake pulse toward the mode controller when either source shows qualified activity. Both inputs arrive as asynchronous digital levels and pass through two-flop synchronisers before any edge or level is judged. A high bus level is idle, and a low bus level is driven activity.

A build-time parameter picks the bus qualification rule. In the falling variant, the bus must fall and then stay low for a short debounce count. In the rising variant, the bus must fall and stay low for a longer count, and the wake is raised only when the bus later returns high. With the rising rule, a bus that sinks low and never comes back (for example, with every pull-up removed) wakes nobody. A falling edge on the wake pin is a wake in both variants.

The block acts only while `sleep_en` is high. It fires at most once per sleep period and is re-armed by taking `sleep_en` low for at least one cycle. Debounce times are counted in clock cycles, so the integrator converts microseconds into cycles at the chosen clock.

Top module: `bus_wake_detect`

## Requirements
- R1: After reset, `wake_pulse` and `wake_from_bus` are both 0.
- R2: Falling variant (RISE_WAKE=0): when the bus goes from high to low and the synchronised level then stays low for SHORT_LOW_CYC cycles, exactly one `wake_pulse` is raised while the bus is still low, with `wake_from_bus`=1.
- R3: Falling variant: a low period shorter than SHORT_LOW_CYC produces no wake. The low-time count clears whenever the bus is high, so separate short lows never add up.
- R4: Rising variant (RISE_WAKE=1): a low period of at least LONG_LOW_CYC cycles that starts with a falling edge, followed by a return to high, raises one `wake_pulse` in the cycle after the synchronised rise, with `wake_from_bus`=1.
- R5: Rising variant: a bus that goes low and stays low, however long, never produces a wake.
- R6: Rising variant: a low period shorter than LONG_LOW_CYC followed by a rise produces no wake.
- R7: A high-to-low edge on `wake_pin_n` raises one `wake_pulse` with `wake_from_bus`=0, in both variants.
- R8: While `sleep_en` is 0, no wake pulse is raised, and no activity seen during that time leads to a later pulse.
- R9: `wake_pulse` lasts one cycle and fires at most once per period of `sleep_en`=1. A 0 on `sleep_en` for at least one cycle re-arms it.
- R10: A bus that is already low when `sleep_en` rises has shown no falling edge, so it produces no bus wake in either variant, even after it later returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | High while the node is in power-down; enables detection |
| bus_lvl | input | 1 | Asynchronous bus level, 1 = idle/high, 0 = driven low |
| wake_pin_n | input | 1 | Asynchronous local wake pin, active on a falling edge |
| wake_pulse | output | 1 | Registered one-cycle wake request |
| wake_from_bus | output | 1 | Registered source of the last wake: 1 = bus, 0 = pin |

## Verification
On every cycle, the assertions check the following:
- the pulse is one cycle wide and never follows a disabled cycle;
- the low-time counter saturates and clears on a high level;
- a bus wake in the falling variant happens with the bus low;
- a bus wake in the rising variant happens only on a low-to-high transition.

The thresholds themselves can only be shown by the bench's scenarios. These scenarios drive short, medium, long and endless low periods into both variants side by side. They also cover the following cases:
- a bus already low when sleep begins;
- repeated activity within one sleep period;
- pin wakes;
- activity while detection is disabled.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bwd_low_timer.sv
module bwd_low_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic lvl,
  input  logic lvl_prev,
  output logic qual
);
  localparam int unsigned CW = bwd_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // Counting starts only on a high-to-low step and saturates at CAP.
  always_ff @(posedge clk) begin
    if (rst || !run || lvl) begin
      cnt <= '0;
    end else if ((cnt != '0) || lvl_prev) begin
      if (cnt != CAP) cnt <= cnt + 1'b1;
    end
  end

  assign qual = (cnt == CAP);

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP); // R2
  AST_CNT_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
    lvl |=> (cnt == '0)); // R3
endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect #(
  parameter bit          RISE_WAKE     = 1'b0,
  parameter int unsigned SHORT_LOW_CYC = 8,
  parameter int unsigned LONG_LOW_CYC  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_en,
  input  logic bus_lvl,
  input  logic wake_pin_n,
  output logic wake_pulse,
  output logic wake_from_bus
);
  localparam int unsigned LOW_LIMIT = RISE_WAKE ? LONG_LOW_CYC : SHORT_LOW_CYC;

  logic [1:0] raw_in, sync_out;
  logic bus_s, pin_s, bus_q, pin_q;
  logic qual, bus_hit, pin_hit, fire, armed;

  assign raw_in = {wake_pin_n, bus_lvl};

  bwd_sync #(.WIDTH(2), .STAGES(bwd_pkg::SYNC_DEPTH), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign bus_s = sync_out[0];
  assign pin_s = sync_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= 1'b1;
      pin_q <= 1'b1;
    end else begin
      bus_q <= bus_s;
      pin_q <= pin_s;
    end
  end

  bwd_low_timer #(.LIMIT(LOW_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .run(sleep_en),
    .lvl(bus_s), .lvl_prev(bus_q), .qual(qual)
  );

  generate
    if (RISE_WAKE) begin : g_rise
      assign bus_hit = qual & bus_s & ~bus_q;
      AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse && wake_from_bus) |-> ($past(bus_s) && !$past(bus_q))); // R4
    end else begin : g_fall
      assign bus_hit = qual & ~bus_s;
      AST_FALL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse && wake_from_bus) |-> !$past(bus_s)); // R2
    end
  endgenerate

  assign pin_hit = pin_q & ~pin_s;
  assign fire    = sleep_en & armed & (bus_hit | pin_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_pulse    <= 1'b0;
      wake_from_bus <= 1'b0;
      armed         <= 1'b1;
    end else begin
      wake_pulse <= fire;
      if (fire) wake_from_bus <= bus_hit;
      if (!sleep_en)  armed <= 1'b1;
      else if (fire)  armed <= 1'b0;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R9
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !sleep_en |=> !wake_pulse); // R8
endmodule

// File: tb/tb_bus_wake_detect.sv
module tb_bus_wake_detect;
  localparam int SHORT = 8;
  localparam int LONG  = 20;

  logic clk = 1'b0, rst = 1'b1, sleep_en = 1'b0, bus_lvl = 1'b1, pin_n = 1'b1;
  logic wp_f, src_f, wp_r, src_r;
  int checks = 0, fails = 0;
  int cnt_f = 0, cnt_r = 0, run_f = 0, run_r = 0, maxrun_f = 0, maxrun_r = 0;
  logic last_src_f = 1'b0, last_src_r = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_wake_detect #(.RISE_WAKE(1'b0), .SHORT_LOW_CYC(SHORT), .LONG_LOW_CYC(LONG)) dut (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .bus_lvl(bus_lvl),
    .wake_pin_n(pin_n), .wake_pulse(wp_f), .wake_from_bus(src_f));

  bus_wake_detect #(.RISE_WAKE(1'b1), .SHORT_LOW_CYC(SHORT), .LONG_LOW_CYC(LONG)) dut_rise (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .bus_lvl(bus_lvl),
    .wake_pin_n(pin_n), .wake_pulse(wp_r), .wake_from_bus(src_r));

  always @(negedge clk) begin
    if (wp_f) begin run_f++; if (run_f == 1) cnt_f++; last_src_f = src_f; end else run_f = 0;
    if (wp_r) begin run_r++; if (run_r == 1) cnt_r++; last_src_r = src_r; end else run_r = 0;
    if (run_f > maxrun_f) maxrun_f = run_f;
    if (run_r > maxrun_r) maxrun_r = run_r;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    cnt_f = 0; cnt_r = 0; maxrun_f = 0; maxrun_r = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    sleep_en = 1'b0; cycles(3);
    clear_counts();
    sleep_en = 1'b1; cycles(4);
  endtask

  task automatic low_pulse(input int len, input bit go_high);
    bus_lvl = 1'b0; cycles(len);
    if (go_high) bus_lvl = 1'b1;
  endtask

  // Scenario table: bus low length, return high, pin used, expected wakes (fall, rise)
  localparam int NV = 6;
  localparam int V_LEN [NV] = '{3, 12, 30, 40, 0, 5};
  localparam bit V_HI  [NV] = '{1,  1,  1,  0, 1, 1};
  localparam bit V_PIN [NV] = '{0,  0,  0,  0, 1, 0};
  localparam int V_EF  [NV] = '{0,  1,  1,  1, 1, 0};
  localparam int V_ER  [NV] = '{0,  0,  1,  0, 1, 0};
  localparam string V_REQ [NV] = '{"R3/R6", "R2/R6", "R2/R4", "R5", "R7", "R3"};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cycles(5);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    check(wp_f == 1'b0 && src_f == 1'b0, "R1 fall", {wp_f, src_f}, 0);
    check(wp_r == 1'b0 && src_r == 1'b0, "R1 rise", {wp_r, src_r}, 0);

    for (int v = 0; v < NV; v++) begin
      rearm();
      if (V_PIN[v]) begin
        pin_n = 1'b0; cycles(3); pin_n = 1'b1;
      end else begin
        low_pulse(V_LEN[v], V_HI[v]);
      end
      cycles(40);
      check(cnt_f == V_EF[v], {V_REQ[v], " fall count"}, cnt_f, V_EF[v]);
      check(cnt_r == V_ER[v], {V_REQ[v], " rise count"}, cnt_r, V_ER[v]);
      if (cnt_f > 0) check(last_src_f == !V_PIN[v], {V_REQ[v], " fall src"}, last_src_f, !V_PIN[v]);
      if (cnt_r > 0) check(last_src_r == !V_PIN[v], {V_REQ[v], " rise src"}, last_src_r, !V_PIN[v]);
      bus_lvl = 1'b1; cycles(5);
    end

    // R3: two short lows separated by high do not accumulate
    rearm();
    low_pulse(5, 1); cycles(1); low_pulse(5, 1); cycles(30);
    check(cnt_f == 0, "R3 no accumulation", cnt_f, 0);

    // R8: activity while disabled is ignored, and nothing follows on enable
    sleep_en = 1'b0; cycles(3); clear_counts();
    low_pulse(30, 1); cycles(3);
    pin_n = 1'b0; cycles(3); pin_n = 1'b1; cycles(10);
    sleep_en = 1'b1; cycles(30);
    check(cnt_f == 0 && cnt_r == 0, "R8 disabled", cnt_f + cnt_r, 0);

    // R9: repeated activity in one period gives one single-cycle pulse
    rearm();
    low_pulse(30, 1); cycles(10); low_pulse(30, 1); cycles(5);
    pin_n = 1'b0; cycles(3); pin_n = 1'b1; cycles(20);
    check(cnt_f == 1, "R9 fall once", cnt_f, 1);
    check(cnt_r == 1, "R9 rise once", cnt_r, 1);
    check(maxrun_f == 1 && maxrun_r == 1, "R9 width", maxrun_f + maxrun_r, 2);
    rearm();
    low_pulse(30, 1); cycles(20);
    check(cnt_f == 1 && cnt_r == 1, "R9 rearmed", cnt_f + cnt_r, 2);

    // R10: bus already low when sleep begins
    sleep_en = 1'b0; bus_lvl = 1'b0; cycles(6); clear_counts();
    sleep_en = 1'b1; cycles(40);
    bus_lvl = 1'b1; cycles(20);
    check(cnt_f == 0 && cnt_r == 0, "R10 no edge", cnt_f + cnt_r, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule